// File: doc/BRIEF.md
# Code-Density Histogram Linearity Analyzer

This block measures the static linearity of a data converter from its output code stream. A start command clears one occurrence counter per output code and loads a sample target. While the block reports itself armed, every valid code adds one hit to its own bin. The end bins are still counted, but the averaging leaves them out. Once the target number of samples has been accepted, counting stops and a post-processing pass runs without further input.

The pass sums the interior bins, which are every code except the lowest and the highest. It then divides each interior bin by the interior average to get a width in LSB, one code at a time, on a bit-serial divider. From that width it derives a differential nonlinearity value, a running integral nonlinearity value and a missing-code flag. These leave the block as one beat per code on a valid/ready stream, in ascending code order. If the interior holds no hits at all, nothing is divided and an invalid flag is raised instead.

Top module: `code_density_analyzer`

## Requirements
- R1: A pulse on `start` zeroes every bin, clears `done`, `ovf_err` and `invalid`, and latches `target`. `armed` is high only during the collection phase that follows the clearing sweep. Samples presented while `armed` is low leave every bin unchanged.
- R2: In each cycle where `armed` and `smp_valid` are both high, bin `smp_code` gains one. Collection ends after exactly `target` accepted samples, and a target of zero accepts none.
- R3: A bin already at 2^BIN_W−1 stays there when hit again, and `ovf_err` goes high and stays high until the next `start`.
- R4: Results come out for codes 1 through 2^CODE_W−2 in ascending order, one beat per code. While `res_valid` is high and `res_ready` is low, every result field holds its value.
- R5: Let S be the sum of the interior bins. For each interior code with count c, `res_dnl` = floor(c·(2^CODE_W−2)·2^FRAC_W / S) − 2^FRAC_W. This is a two's-complement value with FRAC_W fractional bits. The two end bins do not enter S.
- R6: `res_missing` is 1 exactly when the code's bin is zero, and such a beat carries `res_dnl` = −2^FRAC_W (−1 LSB).
- R7: `res_inl` is 0 for code 1. For every later code it equals the sum of the `res_dnl` values of all earlier codes.
- R8: When S is zero, the block raises `invalid` and `done` and emits no result beat.
- R9: `done` rises after the last result beat is accepted and holds until the next `start`. Reset leaves `done`, `armed`, `res_valid`, `ovf_err` and `invalid` all low.
- R10: With CODE_W = 3, FRAC_W = 8 and interior counts 12500, 15000, 12500, 7500, 0, 12500, the block gives DNL 64, 128, 64, −64, −256, 64 and INL 0, 64, 192, 256, 192, −64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clear bins and begin a new measurement |
| target | input | CNT_W | Number of samples to accept, latched on `start` |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | CODE_W | Converter output code |
| armed | output | 1 | High while samples are being counted |
| res_valid | output | 1 | Result beat available |
| res_ready | input | 1 | Consumer accepts the beat |
| res_code | output | CODE_W | Code the beat describes |
| res_dnl | output | CODE_W+FRAC_W+2 | Signed DNL with FRAC_W fractional bits |
| res_inl | output | CODE_W+FRAC_W+2 | Signed running INL with FRAC_W fractional bits |
| res_missing | output | 1 | Code collected no hits |
| done | output | 1 | Measurement and readout finished |
| ovf_err | output | 1 | A bin saturated during collection (sticky) |
| invalid | output | 1 | Interior sum was zero, so no results were produced |

## Verification
A bin that is cleared or incremented wrongly only becomes visible at readout. It changes the DNL of its own code and, through the shared sum S, the DNL of every other code. It then carries into the INL of all later beats. A divider or accumulator fault shows up on the first beat it touches, so results are checked beat by beat against a bench model of the bins. The model is fed random codes, a one-code overflow run, an all-end-bin run, a zero target and the exact six-bin case. Random back-pressure exposes any field that moves during a stall in the very next cycle.

// File: rtl/hla_pkg.sv
package hla_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_COUNT,
    ST_SUM,
    ST_DIV,
    ST_OUT,
    ST_DONE
  } hla_state_e;
endpackage

// File: rtl/hla_bin_mem.sv
module hla_bin_mem #(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/hla_restoring_div.sv
module hla_restoring_div #(
  parameter int NUM_W = 27,
  parameter int DEN_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             q_valid
);
  localparam int CW = $clog2(NUM_W + 1);
  localparam int PW = NUM_W + DEN_W;

  logic [DEN_W-1:0] rem_q;
  logic [NUM_W-1:0] quo_q;
  logic [NUM_W-1:0] num_l;
  logic [CW-1:0]    left_q;
  logic             busy_q;
  logic [DEN_W:0]   rem_sh;
  logic [DEN_W:0]   diff;
  logic             fits;
  logic             unused_top;

  assign rem_sh     = {rem_q, quo_q[NUM_W-1]};
  assign diff       = rem_sh - {1'b0, den};
  assign fits       = rem_sh >= {1'b0, den};
  assign unused_top = diff[DEN_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      quo_q   <= '0;
      num_l   <= '0;
      left_q  <= '0;
      busy_q  <= 1'b0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= 1'b0;
      if (go && !busy_q) begin
        rem_q  <= '0;
        quo_q  <= num;
        num_l  <= num;
        left_q <= CW'(NUM_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= fits ? diff[DEN_W-1:0] : rem_sh[DEN_W-1:0];
        quo_q  <= {quo_q[NUM_W-2:0], fits};
        left_q <= left_q - 1'b1;
        if (left_q == CW'(1)) begin
          busy_q  <= 1'b0;
          q_valid <= 1'b1;
        end
      end
    end
  end

  assign quo = quo_q;

  // R5: a finished quotient satisfies q*d <= n < (q+1)*d
  a_r5_quotient: assert property (@(posedge clk) disable iff (rst)
    q_valid |-> ((PW'(quo_q) * PW'(den)) <= PW'(num_l)) &&
                ((PW'(num_l) - PW'(quo_q) * PW'(den)) < PW'(den)));
endmodule

// File: rtl/code_density_analyzer.sv
module code_density_analyzer
  import hla_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int BIN_W  = 16,
  parameter int CNT_W  = 20,
  parameter int FRAC_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [CNT_W-1:0]              target,
  input  logic                          smp_valid,
  input  logic [CODE_W-1:0]             smp_code,
  output logic                          armed,
  output logic                          res_valid,
  input  logic                          res_ready,
  output logic [CODE_W-1:0]             res_code,
  output logic signed [CODE_W+FRAC_W+1:0] res_dnl,
  output logic signed [CODE_W+FRAC_W+1:0] res_inl,
  output logic                          res_missing,
  output logic                          done,
  output logic                          ovf_err,
  output logic                          invalid
);
  localparam int NB    = 1 << CODE_W;
  localparam int NI    = NB - 2;
  localparam int SUM_W = BIN_W + CODE_W;
  localparam int NUM_W = BIN_W + CODE_W + FRAC_W;
  localparam int DNL_W = CODE_W + FRAC_W + 2;
  localparam logic [BIN_W-1:0]        BIN_MAX = '1;
  localparam logic [CODE_W-1:0]       FIRST   = CODE_W'(1);
  localparam logic [CODE_W-1:0]       LAST    = CODE_W'(NI);
  localparam logic [CODE_W-1:0]       TOPC    = CODE_W'(NB - 1);
  localparam logic signed [DNL_W-1:0] ONE_FX  = DNL_W'(1 << FRAC_W);

  hla_state_e         state_q;
  logic [CODE_W-1:0]  idx_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   tgt_q;
  logic [SUM_W-1:0]   sum_q;
  logic signed [DNL_W-1:0] inl_q;
  logic               div_go_q;
  logic               miss_q;

  logic [CODE_W-1:0]  mem_addr;
  logic               mem_we;
  logic [BIN_W-1:0]   mem_wdata;
  logic [BIN_W-1:0]   rd_data;
  logic [SUM_W-1:0]   sum_next;
  logic [NUM_W-1:0]   num_w;
  logic [NUM_W-1:0]   quo;
  logic               q_valid;
  logic signed [DNL_W-1:0] dnl_w;
  logic               unused_qhi;

  assign mem_addr  = (state_q == ST_COUNT) ? smp_code : idx_q;
  assign mem_we    = (state_q == ST_CLEAR) || (state_q == ST_COUNT && smp_valid && !start);
  assign mem_wdata = (state_q == ST_CLEAR) ? '0 :
                     (rd_data == BIN_MAX) ? rd_data : rd_data + 1'b1;

  hla_bin_mem #(.AW(CODE_W), .DW(BIN_W)) u_bins (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (rd_data)
  );

  assign sum_next = sum_q + SUM_W'(rd_data);
  assign num_w    = (NUM_W'(rd_data) * NUM_W'(NI)) << FRAC_W;

  hla_restoring_div #(.NUM_W(NUM_W), .DEN_W(SUM_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .go      (div_go_q),
    .num     (num_w),
    .den     (sum_q),
    .quo     (quo),
    .q_valid (q_valid)
  );

  assign dnl_w      = $signed({1'b0, quo[DNL_W-2:0]}) - ONE_FX;
  assign unused_qhi = ^quo[NUM_W-1:DNL_W-1];
  assign armed      = (state_q == ST_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      cnt_q       <= '0;
      tgt_q       <= '0;
      sum_q       <= '0;
      inl_q       <= '0;
      div_go_q    <= 1'b0;
      miss_q      <= 1'b0;
      res_valid   <= 1'b0;
      res_code    <= '0;
      res_dnl     <= '0;
      res_inl     <= '0;
      res_missing <= 1'b0;
      done        <= 1'b0;
      ovf_err     <= 1'b0;
      invalid     <= 1'b0;
    end else begin
      div_go_q <= 1'b0;
      if (start) begin
        state_q   <= ST_CLEAR;
        idx_q     <= '0;
        cnt_q     <= '0;
        tgt_q     <= target;
        sum_q     <= '0;
        inl_q     <= '0;
        res_valid <= 1'b0;
        done      <= 1'b0;
        ovf_err   <= 1'b0;
        invalid   <= 1'b0;
      end else begin
        case (state_q)
          ST_CLEAR: begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == TOPC) begin
              idx_q   <= FIRST;
              state_q <= (tgt_q == '0) ? ST_SUM : ST_COUNT;
            end
          end
          ST_COUNT: begin
            if (smp_valid) begin
              cnt_q <= cnt_q + 1'b1;
              if (rd_data == BIN_MAX) ovf_err <= 1'b1;
              if (CNT_W'(cnt_q + 1'b1) == tgt_q) state_q <= ST_SUM;
            end
          end
          ST_SUM: begin
            sum_q <= sum_next;
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST) begin
              if (sum_next == '0) begin
                invalid <= 1'b1;
                done    <= 1'b1;
                state_q <= ST_DONE;
              end else begin
                idx_q    <= FIRST;
                div_go_q <= 1'b1;
                state_q  <= ST_DIV;
              end
            end
          end
          ST_DIV: begin
            if (div_go_q) miss_q <= (rd_data == '0);
            if (q_valid) begin
              res_valid   <= 1'b1;
              res_code    <= idx_q;
              res_dnl     <= dnl_w;
              res_inl     <= inl_q;
              res_missing <= miss_q;
              state_q     <= ST_OUT;
            end
          end
          ST_OUT: begin
            if (res_ready) begin
              res_valid <= 1'b0;
              inl_q     <= inl_q + res_dnl;
              if (idx_q == LAST) begin
                done    <= 1'b1;
                state_q <= ST_DONE;
              end else begin
                idx_q    <= idx_q + 1'b1;
                div_go_q <= 1'b1;
                state_q  <= ST_DIV;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready && !start) |=> res_valid && $stable(res_code) &&
      $stable(res_dnl) && $stable(res_inl) && $stable(res_missing));

  a_r4_range: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_code >= FIRST) && (res_code <= LAST));

  a_r6_missing: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_missing) |-> (res_dnl == -ONE_FX));

  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_err && !start) |=> ovf_err);

  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    invalid |-> !res_valid && done);

  a_r9_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !armed && !res_valid);
endmodule

// File: tb/code_density_analyzer_test.sv
module code_density_analyzer_test;
  localparam int CW = 3;
  localparam int BW = 14;
  localparam int TW = 18;
  localparam int FW = 8;
  localparam int NB = 1 << CW;
  localparam int NI = NB - 2;
  localparam int BMAX = (1 << BW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [TW-1:0] target = '0;
  logic smp_valid = 1'b0;
  logic [CW-1:0] smp_code = '0;
  logic armed, res_valid, res_missing, done, ovf_err, invalid;
  logic res_ready = 1'b0;
  logic [CW-1:0] res_code;
  logic signed [CW+FW+1:0] res_dnl, res_inl;

  int n_chk = 0;
  int n_fail = 0;
  int exp_bin [NB];
  int plan [NB];
  longint got_dnl [NB];
  longint got_inl [NB];

  always #5 clk = ~clk;

  code_density_analyzer #(.CODE_W(CW), .BIN_W(BW), .CNT_W(TW), .FRAC_W(FW)) uut (
    .clk(clk), .rst(rst), .start(start), .target(target),
    .smp_valid(smp_valid), .smp_code(smp_code), .armed(armed),
    .res_valid(res_valid), .res_ready(res_ready), .res_code(res_code),
    .res_dnl(res_dnl), .res_inl(res_inl), .res_missing(res_missing),
    .done(done), .ovf_err(ovf_err), .invalid(invalid)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic begin_run(int tgt);
    @(negedge clk);
    start = 1'b1;
    target = TW'(tgt);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < NB; k++) exp_bin[k] = 0;
  endtask

  // mode 0 random, 1 planned counts, 2 end bins only, 3 code 2 only
  task automatic feed(int mode);
    bit seen = 1'b0;
    int c;
    forever begin
      @(negedge clk);
      if (seen && !armed) break;
      c = 0;
      case (mode)
        0: c = int'($urandom_range(0, NB - 1));
        1: begin
          for (int k = NB - 1; k >= 0; k--) if (plan[k] > 0) c = k;
        end
        2: c = ($urandom % 2) ? NB - 1 : 0;
        default: c = 2;
      endcase
      smp_code = CW'(c);
      smp_valid = (mode == 0) ? (($urandom % 4) != 0) : 1'b1;
      if (armed) begin
        seen = 1'b1;
        if (smp_valid) begin
          if (exp_bin[c] < BMAX) exp_bin[c]++;
          if (mode == 1) plan[c]--;
        end
      end
    end
  endtask

  task automatic collect(bit rnd_ready, bit exp_ovf);
    longint s = 0;
    longint inl = 0;
    longint q;
    int beats = 0;
    bit stalled = 1'b0;
    logic [CW-1:0] sv_code;
    logic signed [CW+FW+1:0] sv_dnl;
    bit rdy;
    for (int k = 1; k <= NI; k++) s += exp_bin[k];
    forever begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_code = CW'($urandom_range(0, NB - 1));
      if (stalled) begin
        chk("R4", "held beat", {res_valid, res_code, res_dnl}, {1'b1, sv_code, sv_dnl});
        stalled = 1'b0;
      end
      if (done) break;
      rdy = rnd_ready ? (($urandom % 3) != 0) : 1'b1;
      res_ready = rdy;
      if (res_valid) begin
        if (rdy) begin
          beats++;
          q = (longint'(exp_bin[beats]) * NI * (1 << FW)) / s;
          chk("R4", "code order", res_code, beats);
          chk("R5", "dnl", res_dnl, q - (1 << FW));
          chk("R6", "missing flag", res_missing, exp_bin[beats] == 0);
          chk("R7", "inl", res_inl, inl);
          got_dnl[beats] = res_dnl;
          got_inl[beats] = res_inl;
          inl += q - (1 << FW);
        end else begin
          stalled = 1'b1;
          sv_code = res_code;
          sv_dnl = res_dnl;
        end
      end
    end
    res_ready = 1'b0;
    smp_valid = 1'b0;
    chk(s == 0 ? "R8" : "R4", "beat count", beats, s == 0 ? 0 : NI);
    chk("R9", "done", done, 1);
    chk("R8", "invalid", invalid, s == 0);
    chk("R3", "overflow flag", ovf_err, exp_ovf);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20231));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "reset res_valid", res_valid, 0);
    chk("R9", "reset done", done, 0);
    chk("R9", "reset armed", armed, 0);
    chk("R9", "reset ovf_err", ovf_err, 0);
    chk("R9", "reset invalid", invalid, 0);

    // R10 worked case with end bins overdriven
    plan = '{1000, 12500, 15000, 12500, 7500, 0, 12500, 2000};
    begin_run(63000);
    feed(1);
    collect(1'b0, 1'b0);
    chk("R10", "dnl code1", got_dnl[1], 64);
    chk("R10", "dnl code2", got_dnl[2], 128);
    chk("R10", "dnl code3", got_dnl[3], 64);
    chk("R10", "dnl code4", got_dnl[4], -64);
    chk("R10", "dnl code5", got_dnl[5], -256);
    chk("R10", "dnl code6", got_dnl[6], 64);
    chk("R10", "inl code4", got_inl[4], 256);
    chk("R10", "inl code6", got_inl[6], -64);

    // R2 random codes with gaps in the strobe, R1 clears previous bins
    begin_run(400);
    feed(0);
    collect(1'b1, 1'b0);
    begin_run(1500);
    feed(0);
    collect(1'b1, 1'b0);

    // R8 only end bins hit, then a zero target
    begin_run(50);
    feed(2);
    collect(1'b1, 1'b0);
    begin_run(0);
    chk("R2", "zero target not armed", armed, 0);
    collect(1'b1, 1'b0);

    // R3 one bin driven past saturation
    begin_run(BMAX + 17);
    feed(3);
    chk("R3", "bin saturated", exp_bin[2], BMAX);
    collect(1'b1, 1'b1);

    // R1 next start clears the sticky flag and the bins
    begin_run(300);
    chk("R1", "ovf cleared by start", ovf_err, 0);
    feed(0);
    collect(1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule